// File: doc/BRIEF.md
# Host Memory Access Port

This block lets an external host reach a processor's on-chip program and data memories through a narrow multiplexed bus. The host sees one 16-bit bus and a small set of strobes: a port select, an address-latch strobe, read and write strobes, and an acknowledge line. The processor side sees a single-word memory request that is held until the core grants it. Each granted request takes one internal memory cycle from the core.

The host first latches a control word. Its top bit decides what the word is. When the top bit is clear, the word carries a memory-space bit and a word address. When the top bit is set, the low bits of the word go into a separate overlay register. After the address is latched, the host moves words one at a time. It raises a strobe, waits for acknowledge to go high and then come back low, and then releases the strobe. The internal address advances after each word, so a block transfer needs only one latch. Program-memory words are 24 bits wide and travel as two bus transfers: the upper 16 bits first, then the low 8 bits.

All host inputs are taken as synchronous to the port clock. The host keeps each strobe asserted until acknowledge has fallen.

Top module: `hmp_port`

## Requirements
- R1: During reset and right after it, acknowledge is low, no memory request is made, the overlay register reads zero, the word address is zero and the bus driver enable is low.
- R2: A cycle with select low and the latch strobe high, with bus bit 15 clear, loads bits 13..0 as the word address and bit 14 as the space bit (1 = program memory, 0 = data memory).
- R3: The same latch cycle with bus bit 15 set loads bits 3..0 into the overlay output and leaves the word address and space bit unchanged.
- R4: Select low with write low (or read low) starts one access. Acknowledge rises on the next cycle and stays high until the access is done. A data-memory write makes one request whose write data is the bus value, zero-extended to 24 bits, at the current address.
- R5: On a read, the read data are on the bus output before acknowledge falls, and they hold steady on the cycle it falls. A data-memory read returns bits 15..0 of the memory word.
- R6: After each completed data-memory word the address advances by one, and it wraps from 0x3FFF to 0.
- R7: A program-memory write takes the upper 16 bits in its first transfer, without any memory request. The second transfer supplies bits 7..0 and makes one request that stores {upper, low}. The address advances only after the second transfer.
- R8: A program-memory read makes one request on its first transfer and returns bits 23..8. The second transfer makes no request and returns {8'h00, bits 7..0}. The address advances only after the second transfer.
- R9: Each memory word costs exactly one granted request cycle. While a request waits for grant, the address, write data and write flag stay constant. The request drops in the cycle after its grant.
- R10: The bus driver enable is high exactly when select and the read strobe are both low.
- R11: A strobe held low after acknowledge has fallen does not start a second access. The next access needs the strobe or select to go high first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Active-low reset |
| hsel_n | input | 1 | Host port select, active low |
| hlatch | input | 1 | Host address-latch strobe, active high |
| hrd_n | input | 1 | Host read strobe, active low |
| hwr_n | input | 1 | Host write strobe, active low |
| hbus_in | input | 16 | Host bus value seen by the port |
| hbus_out | output | 16 | Read data driven toward the host |
| hbus_oe | output | 1 | Enable for the host bus driver |
| hack | output | 1 | Access acknowledge, high while busy |
| ovl_out | output | 4 | Overlay register |
| mreq | output | 1 | Internal memory request |
| mwe | output | 1 | Request is a write |
| mpm | output | 1 | Request targets program memory |
| maddr | output | 14 | Word address of the request |
| mwdata | output | 24 | Write data of the request |
| mgnt | input | 1 | Core grants the pending request this cycle |
| mrdata | input | 24 | Read data, valid the cycle after grant |

## Verification
Data-memory bursts after a single latch show whether the address advances, and a burst started at the top address shows the wrap to zero. Program-memory transfers split into halves show whether a request is made on the correct half, by comparing grant counts before and after each half. They also show that the address advances only once per 24-bit word. An overlay latch placed between two bursts shows whether the address is disturbed. A deliberately long strobe shows whether one access is counted twice. Random words written to random addresses with a randomly withheld grant, then read back and compared with a model in the bench, expose errors in data capture and errors in holding a request until it is granted.

// File: rtl/hmp_pkg.sv
package hmp_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_CAP  = 2'd2,
      ST_FIN  = 2'd3
   } hmp_state_e;
endpackage

// File: rtl/hmp_ctrlreg.sv
module hmp_ctrlreg #(
   parameter int AW     = 14,
   parameter int DW     = 16,
   parameter int OVL_W  = 4,
   parameter bit OVL_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             latch_en,
   input  logic [DW-1:0]    bus,
   input  logic             inc,
   output logic [AW-1:0]    addr,
   output logic             pm_sel,
   output logic [OVL_W-1:0] ovl
);
   localparam int KIND_BIT  = DW - 1;
   localparam int SPACE_BIT = DW - 2;

   logic is_ovl;
   assign is_ovl = bus[KIND_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr   <= '0;
         pm_sel <= 1'b0;
      end else if (latch_en && !is_ovl) begin
         addr   <= bus[AW-1:0];
         pm_sel <= bus[SPACE_BIT];
      end else if (inc) begin
         addr   <= addr + 1'b1;
      end
   end

   generate
      if (OVL_EN) begin : g_ovl
         logic [OVL_W-1:0] ovl_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 ovl_q <= '0;
            else if (latch_en && is_ovl) ovl_q <= bus[OVL_W-1:0];
         end
         assign ovl = ovl_q;
      end else begin : g_no_ovl
         assign ovl = '0;
      end
   endgenerate
endmodule

// File: rtl/hmp_seq.sv
module hmp_seq
   import hmp_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start_wr,
   input  logic start_rd,
   input  logic pm_sel,
   input  logic clr_half,
   input  logic mgnt,
   output logic mreq,
   output logic mwe,
   output logic inc,
   output logic ack,
   output logic ld_hi,
   output logic ld_wd,
   output logic ld_lo,
   output logic ld_cap
);
   hmp_state_e st_q, st_d;
   logic       half_q;
   logic       we_q;
   logic       idle;

   assign idle   = (st_q == ST_IDLE);
   assign ld_hi  = idle && start_wr && pm_sel && !half_q;
   assign ld_wd  = idle && start_wr && !(pm_sel && !half_q);
   assign ld_lo  = idle && start_rd && pm_sel && half_q;
   assign ld_cap = (st_q == ST_CAP);
   assign mreq   = (st_q == ST_REQ);
   assign mwe    = we_q;
   assign ack    = !idle;
   assign inc    = ld_lo
                 | ((st_q == ST_REQ) && mgnt && we_q)
                 | (ld_cap && !pm_sel);

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE: begin
            if (ld_hi || ld_lo)          st_d = ST_FIN;
            else if (ld_wd || start_rd)  st_d = ST_REQ;
         end
         ST_REQ:  if (mgnt) st_d = we_q ? ST_FIN : ST_CAP;
         ST_CAP:  st_d = ST_FIN;
         ST_FIN:  st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         half_q <= 1'b0;
         we_q   <= 1'b0;
      end else begin
         st_q <= st_d;
         if (clr_half)                half_q <= 1'b0;
         else if (ld_hi)              half_q <= 1'b1;
         else if (ld_wd || ld_lo)     half_q <= 1'b0;
         else if (ld_cap && pm_sel)   half_q <= 1'b1;
         if (ld_wd)                   we_q <= 1'b1;
         else if (idle && start_rd)   we_q <= 1'b0;
      end
   end
endmodule

// File: rtl/hmp_dpath.sv
module hmp_dpath #(
   parameter int DW = 16,
   parameter int PW = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] bus,
   input  logic          pm_sel,
   input  logic          ld_hi,
   input  logic          ld_wd,
   input  logic          ld_lo,
   input  logic          ld_cap,
   input  logic [PW-1:0] mrdata,
   output logic [PW-1:0] mwdata,
   output logic [DW-1:0] rd_out
);
   localparam int LOW_W = PW - DW;

   logic [DW-1:0]    hi_q;
   logic [PW-1:0]    wd_q;
   logic [LOW_W-1:0] lo_q;
   logic [DW-1:0]    rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q <= '0;
         wd_q <= '0;
         lo_q <= '0;
         rd_q <= '0;
      end else begin
         if (ld_hi) hi_q <= bus;
         if (ld_wd) wd_q <= pm_sel ? {hi_q, bus[LOW_W-1:0]}
                                   : {{(PW-DW){1'b0}}, bus};
         if (ld_cap) begin
            lo_q <= mrdata[LOW_W-1:0];
            rd_q <= pm_sel ? mrdata[PW-1 -: DW] : mrdata[DW-1:0];
         end else if (ld_lo) begin
            rd_q <= {{(DW-LOW_W){1'b0}}, lo_q};
         end
      end
   end

   assign mwdata = wd_q;
   assign rd_out = rd_q;
endmodule

// File: rtl/hmp_port.sv
module hmp_port #(
   parameter int AW     = 14,
   parameter int DW     = 16,
   parameter int PW     = 24,
   parameter int OVL_W  = 4,
   parameter bit OVL_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hsel_n,
   input  logic             hlatch,
   input  logic             hrd_n,
   input  logic             hwr_n,
   input  logic [DW-1:0]    hbus_in,
   output logic [DW-1:0]    hbus_out,
   output logic             hbus_oe,
   output logic             hack,
   output logic [OVL_W-1:0] ovl_out,
   output logic             mreq,
   output logic             mwe,
   output logic             mpm,
   output logic [AW-1:0]    maddr,
   output logic [PW-1:0]    mwdata,
   input  logic             mgnt,
   input  logic [PW-1:0]    mrdata
);
   initial begin
      if (PW <= DW || PW > 2 * DW) $error("hmp_port: PW must lie in (DW, 2*DW]");
      if (AW > DW - 2)             $error("hmp_port: AW must leave room for kind and space bits");
      if (OVL_W < 1 || OVL_W > AW) $error("hmp_port: OVL_W out of range");
   end

   logic acc_wr, acc_rd, used_q, start_wr, start_rd, latch_en;
   logic inc, ack, ld_hi, ld_wd, ld_lo, ld_cap, pm_sel;

   assign acc_wr   = !hsel_n && !hwr_n;
   assign acc_rd   = !hsel_n && !hrd_n;
   assign latch_en = !hsel_n && hlatch;
   assign start_wr = acc_wr && !used_q && !ack;
   assign start_rd = acc_rd && !acc_wr && !used_q && !ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    used_q <= 1'b0;
      else if (!(acc_wr || acc_rd))  used_q <= 1'b0;
      else if (start_wr || start_rd) used_q <= 1'b1;
   end

   hmp_ctrlreg #(.AW(AW), .DW(DW), .OVL_W(OVL_W), .OVL_EN(OVL_EN)) u_creg (
      .clk(clk), .rst_n(rst_n), .latch_en(latch_en), .bus(hbus_in),
      .inc(inc), .addr(maddr), .pm_sel(pm_sel), .ovl(ovl_out)
   );

   hmp_seq u_seq (
      .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .start_rd(start_rd),
      .pm_sel(pm_sel), .clr_half(latch_en), .mgnt(mgnt), .mreq(mreq),
      .mwe(mwe), .inc(inc), .ack(ack), .ld_hi(ld_hi), .ld_wd(ld_wd),
      .ld_lo(ld_lo), .ld_cap(ld_cap)
   );

   hmp_dpath #(.DW(DW), .PW(PW)) u_dp (
      .clk(clk), .rst_n(rst_n), .bus(hbus_in), .pm_sel(pm_sel),
      .ld_hi(ld_hi), .ld_wd(ld_wd), .ld_lo(ld_lo), .ld_cap(ld_cap),
      .mrdata(mrdata), .mwdata(mwdata), .rd_out(hbus_out)
   );

   assign hack    = ack;
   assign mpm     = pm_sel;
   assign hbus_oe = acc_rd;
endmodule

// File: rtl/hmp_chk.sv
module hmp_chk #(
   parameter int AW = 14,
   parameter int DW = 16,
   parameter int PW = 24
) (
   input logic          clk,
   input logic          rst_n,
   input logic          hsel_n,
   input logic          hrd_n,
   input logic          hwr_n,
   input logic          hack,
   input logic          mreq,
   input logic          mgnt,
   input logic          mwe,
   input logic [AW-1:0] maddr,
   input logic [PW-1:0] mwdata,
   input logic [DW-1:0] hbus_out
);
   assert_reset_R1: assert property (@(posedge clk)
      !rst_n |=> (!hack && !mreq));

   assert_ack_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hack) |-> $past(!hsel_n && (!hwr_n || !hrd_n)));

   assert_req_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mreq |-> hack);

   assert_rd_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hack) |-> $stable(hbus_out));

   assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mreq && !mgnt) |=> (mreq && $stable(maddr) && $stable(mwdata) && $stable(mwe)));

   assert_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mreq && mgnt) |=> !mreq);
endmodule

bind hmp_port hmp_chk #(.AW(AW), .DW(DW), .PW(PW)) u_chk (
   .clk(clk), .rst_n(rst_n), .hsel_n(hsel_n), .hrd_n(hrd_n), .hwr_n(hwr_n),
   .hack(hack), .mreq(mreq), .mgnt(mgnt), .mwe(mwe), .maddr(maddr),
   .mwdata(mwdata), .hbus_out(hbus_out)
);

// File: tb/sim_hmp_port.sv
module sim_hmp_port;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hsel_n = 1'b1, hlatch = 1'b0, hrd_n = 1'b1, hwr_n = 1'b1;
   logic [15:0] hbus_in = '0;
   logic [15:0] hbus_out;
   logic        hbus_oe, hack, mreq, mwe, mpm, mgnt = 1'b1;
   logic [3:0]  ovl_out;
   logic [13:0] maddr;
   logic [23:0] mwdata, mrdata = '0;

   logic [23:0] dmem [64];
   logic [23:0] pmem [64];
   logic [15:0] exp_d [64];
   int unsigned gcnt = 0;
   int unsigned n_chk = 0, n_bad = 0;
   bit          rand_gnt = 1'b0;
   bit          done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hmp_port u0 (
      .clk(clk), .rst_n(rst_n), .hsel_n(hsel_n), .hlatch(hlatch), .hrd_n(hrd_n),
      .hwr_n(hwr_n), .hbus_in(hbus_in), .hbus_out(hbus_out), .hbus_oe(hbus_oe),
      .hack(hack), .ovl_out(ovl_out), .mreq(mreq), .mwe(mwe), .mpm(mpm),
      .maddr(maddr), .mwdata(mwdata), .mgnt(mgnt), .mrdata(mrdata)
   );

   // memory responder: data returned the cycle after grant
   always @(posedge clk) begin
      if (rst_n && mreq && mgnt) begin
         gcnt <= gcnt + 1;
         if (mwe) begin
            if (mpm) pmem[maddr[5:0]] <= mwdata;
            else     dmem[maddr[5:0]] <= mwdata;
         end else begin
            mrdata <= mpm ? pmem[maddr[5:0]] : dmem[maddr[5:0]];
         end
      end
   end

   always @(negedge clk) mgnt <= rand_gnt ? (($urandom % 3) != 0) : 1'b1;

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic latch(input logic [15:0] w);
      @(negedge clk);
      hsel_n = 1'b0; hlatch = 1'b1; hbus_in = w;
      @(negedge clk);
      hsel_n = 1'b1; hlatch = 1'b0;
   endtask

   task automatic wait_ack(input string tag);
      int n = 0;
      while (!hack && n < 100) begin @(negedge clk); n++; end
      while (hack && n < 100)  begin @(negedge clk); n++; end
      if (n >= 100) check(1'b0, {tag, " ack timeout"}, 32'(hack), 0);
   endtask

   task automatic hwrite(input logic [15:0] v, input int extra);
      @(negedge clk);
      hsel_n = 1'b0; hwr_n = 1'b0; hbus_in = v;
      @(negedge clk);
      wait_ack("R4");
      repeat (extra) @(negedge clk);
      hsel_n = 1'b1; hwr_n = 1'b1;
   endtask

   task automatic hread(output logic [15:0] v, output bit oe_seen);
      @(negedge clk);
      hsel_n = 1'b0; hrd_n = 1'b0;
      @(negedge clk);
      oe_seen = hbus_oe;
      wait_ack("R5");
      v = hbus_out;
      hsel_n = 1'b1; hrd_n = 1'b1;
   endtask

   function automatic logic [23:0] pm_word(input logic [15:0] hi, input logic [15:0] lo);
      return {hi, lo[7:0]};
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         check(1'b0, "watchdog", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] rv;
      bit          oe;
      int unsigned g0;
      void'($urandom(32'h5EED_0042));
      for (int i = 0; i < 64; i++) begin dmem[i] = '0; pmem[i] = '0; exp_d[i] = '0; end
      repeat (3) @(negedge clk);
      check(!hack && !mreq, "R1 idle in reset", {hack, mreq}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!hack && !mreq && ovl_out == 0 && maddr == 0, "R1 after reset",
            {hack, mreq, ovl_out, maddr}, 0);
      check(hbus_oe == 1'b0, "R10 oe idle", hbus_oe, 0);

      // R2 R4 R6: data burst from address 5
      latch(16'h0005);
      check(maddr == 14'd5 && mpm == 1'b0, "R2 address latch", {mpm, maddr}, 5);
      g0 = gcnt;
      hwrite(16'h1111, 0); hwrite(16'h2222, 0); hwrite(16'h3333, 0);
      check(dmem[5] == 24'h001111, "R4 write word0", dmem[5], 24'h1111);
      check(dmem[6] == 24'h002222 && dmem[7] == 24'h003333, "R6 burst increment",
            {dmem[6][15:0], dmem[7][15:0]}, 32'h22223333);
      check(gcnt - g0 == 3, "R9 one grant per word", gcnt - g0, 3);

      // R3: overlay latch keeps the address
      latch(16'h8003);
      check(ovl_out == 4'h3, "R3 overlay load", ovl_out, 3);
      check(maddr == 14'd8, "R3 address unchanged", maddr, 8);
      hwrite(16'h4444, 0);
      check(dmem[8] == 24'h004444, "R3 burst continues", dmem[8], 24'h4444);

      // R5 R10: read back
      latch(16'h0005);
      hread(rv, oe);
      check(rv == 16'h1111, "R5 read word0", rv, 16'h1111);
      check(oe == 1'b1, "R10 oe during read", oe, 1);
      hread(rv, oe);
      check(rv == 16'h2222, "R5 read word1", rv, 16'h2222);
      @(negedge clk);
      check(hbus_oe == 1'b0, "R10 oe after read", hbus_oe, 0);

      // R6: wrap
      latch(16'h3FFF);
      hwrite(16'hAAAA, 0); hwrite(16'hBBBB, 0);
      check(dmem[63] == 24'h00AAAA && dmem[0] == 24'h00BBBB, "R6 wrap",
            {dmem[63][15:0], dmem[0][15:0]}, 32'hAAAABBBB);
      check(maddr == 14'd1, "R6 address after wrap", maddr, 1);

      // R7: program write in halves
      latch(16'h400A);
      check(mpm == 1'b1 && maddr == 14'd10, "R2 space bit", {mpm, maddr}, 32'h400A);
      g0 = gcnt;
      hwrite(16'hABCD, 0);
      check(gcnt == g0 && maddr == 14'd10, "R7 first half no request",
            gcnt - g0, 0);
      hwrite(16'h12EF, 0);
      check(pmem[10] == 24'hABCDEF, "R7 word store", pmem[10], 24'hABCDEF);
      check(gcnt - g0 == 1 && maddr == 14'd11, "R7 one request advance",
            gcnt - g0, 1);
      hwrite(16'h5566, 0); hwrite(16'h0088, 0);
      check(pmem[11] == pm_word(16'h5566, 16'h0088), "R7 second word", pmem[11],
            pm_word(16'h5566, 16'h0088));

      // R8: program read in halves
      latch(16'h400A);
      g0 = gcnt;
      hread(rv, oe);
      check(rv == 16'hABCD && gcnt - g0 == 1, "R8 upper half", rv, 16'hABCD);
      hread(rv, oe);
      check(rv == 16'h00EF && gcnt - g0 == 1, "R8 lower half", rv, 16'h00EF);
      hread(rv, oe);
      check(rv == 16'h5566, "R8 address advanced", rv, 16'h5566);

      // R11: long strobe counts once
      latch(16'h0014);
      g0 = gcnt;
      hwrite(16'h7777, 6);
      check(gcnt - g0 == 1 && maddr == 14'd21, "R11 single access",
            gcnt - g0, 1);
      check(hack == 1'b0, "R11 ack stays low", hack, 0);

      // random traffic with withheld grants (R4 R5 R9)
      rand_gnt = 1'b1;
      latch(16'h0020);
      for (int i = 0; i < 16; i++) begin
         logic [15:0] v = 16'($urandom);
         hwrite(v, int'($urandom % 3));
         exp_d[32 + i] = v;
      end
      for (int i = 0; i < 24; i++) begin
         int unsigned a = 32 + ($urandom % 16);
         logic [15:0] v = 16'($urandom);
         latch(16'(a));
         hwrite(v, 0);
         exp_d[a] = v;
      end
      latch(16'h0020);
      for (int i = 0; i < 16; i++) begin
         hread(rv, oe);
         check(rv == exp_d[32 + i], "R5 random readback", rv, exp_d[32 + i]);
      end
      rand_gnt = 1'b0;

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule